// File: doc/BRIEF.md
# GPIO Edge Detect and Interrupt Aggregator

This block watches 128 synchronised general-purpose pin levels, arranged as four banks of 32, and records level transitions on pins configured as inputs. Each pin has its own enable for rising transitions and its own enable for falling transitions. A recorded transition sets a sticky status bit that stays set until software clears it. Software clears bits by pulsing the strobe of one bank together with a data word: every bit where that word holds a 1 is cleared.

The status vector is merged onto three registered interrupt lines. Pin 0 and pin 1 each have a line of their own. A third line is raised when any status bit of pins 2 to 127 is set.

A separate wake request pulses for one cycle when the processor reports that it is halted and a wake-capable input pin changes level. A constant mask parameter lists the wake-capable pins. The block is placed after the pin synchronisers and next to the register file, which holds the direction and enable settings.

Top module: `gpio_edge_aggr`

## Requirements
- R1: A pin's status bit is set at the clock edge where its level is 1, its level one cycle earlier was 0, its rising enable is 1, and its direction bit is 0 (input); the bit shows on `edge_sts[bank*32+bit]` just after that edge.
- R2: A pin's status bit is set at the clock edge where its level is 0, its level one cycle earlier was 1, its falling enable is 1, and its direction bit is 0; a falling level with only the rising enable set leaves the bit clear.
- R3: A pin whose direction bit is 1 (output) never sets its status bit, whatever its enables and level changes.
- R4: Status bits are sticky. A clock edge with `clr_stb[b]` high clears, in bank b only, each bit where `clr_data` holds a 1; the other bits of bank b and all other banks keep their value.
- R5: If a transition and a clear hit the same bit at the same edge, the bit ends up set.
- R6: `irq_pin0` equals status bit 0 and `irq_pin1` equals status bit 1, each one clock after the status value.
- R7: `irq_shared` is the OR of status bits 2 to 127, one clock after the status value.
- R8: `wake_req` is high for the one cycle after an edge at which `cpu_halted` is 1 and an input pin whose bit is set in the wake mask has changed level. The mask words for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. The rising and falling enables play no part.
- R9: After reset, status, all interrupt lines and `wake_req` are 0. No transition is detected on the first clock edge after reset, so a pin held at 1 through reset sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 128 | Synchronised pin levels, index bank*32+bit |
| pin_dir | input | 128 | Direction per pin, 1 = output, 0 = input |
| rise_en | input | 128 | Rising transition enable per pin |
| fall_en | input | 128 | Falling transition enable per pin |
| clr_stb | input | 4 | Clear strobe, bit b selects bank b |
| clr_data | input | 32 | Bits to clear in the strobed bank(s) |
| cpu_halted | input | 1 | Processor halted indication |
| edge_sts | output | 128 | Sticky transition status |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for pins 2 to 127 |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
A pin change, a direction or enable change, and a clear are all applied at one clock edge. The status bit they affect shows after that same edge, and the bench samples it at the following falling edge. The interrupt lines come one register later, so the bench checks them at two points: one sample after the status change, when the line must still hold its old value, and a second sample one cycle later, when it must have followed the status. The wake pulse is registered at the edge where the level change is seen. It is sampled high at the falling edge after that clock edge and sampled low one cycle later.

// File: rtl/gpio_eda_pkg.sv
package gpio_eda_pkg;
  parameter int unsigned DEF_BANKS  = 4;
  parameter int unsigned DEF_BANK_W = 32;
  // wake-capable pins, bank 3 in the top word down to bank 0 in the bottom word
  parameter logic [DEF_BANKS*DEF_BANK_W-1:0] DEF_WAKE_MASK =
    128'h0012007F_EC080000_002001FC_8003FE1B;
endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int unsigned BANK_W = 32,
  parameter logic [BANK_W-1:0] WAKE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              primed,
  input  logic [BANK_W-1:0] lvl,
  input  logic [BANK_W-1:0] dir,
  input  logic [BANK_W-1:0] rise_en,
  input  logic [BANK_W-1:0] fall_en,
  input  logic              clr_stb,
  input  logic [BANK_W-1:0] clr_data,
  output logic [BANK_W-1:0] status,
  output logic              wake_hit
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] sts_q, sts_d;
  logic [BANK_W-1:0] rise_hit, fall_hit, clr_mask, in_mask;

  // next-state logic
  always_comb begin
    in_mask  = ~dir & {BANK_W{primed}};
    rise_hit = lvl & ~prev_q & rise_en & in_mask;
    fall_hit = ~lvl & prev_q & fall_en & in_mask;
    clr_mask = clr_stb ? clr_data : '0;
    // a new transition takes priority over a clear of the same bit
    sts_d    = (sts_q & ~clr_mask) | rise_hit | fall_hit;
    wake_hit = |((lvl ^ prev_q) & in_mask & WAKE_MASK);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sts_q  <= '0;
    end else begin
      prev_q <= lvl;
      sts_q  <= sts_d;
    end
  end

  assign status = sts_q;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_PINS  = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  status,
  input  logic [NUM_BANKS-1:0] wake_hit,
  input  logic                 cpu_halted,
  output logic                 irq_pin0,
  output logic                 irq_pin1,
  output logic                 irq_shared,
  output logic                 wake_req
);
  logic irq0_d, irq1_d, irqx_d, wake_d;
  logic irq0_q, irq1_q, irqx_q, wake_q;

  always_comb begin
    irq0_d = status[0];
    irq1_d = status[1];
    irqx_d = |status[NUM_PINS-1:2];
    wake_d = cpu_halted & (|wake_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
      irqx_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq0_q <= irq0_d;
      irq1_q <= irq1_d;
      irqx_q <= irqx_d;
      wake_q <= wake_d;
    end
  end

  assign irq_pin0   = irq0_q;
  assign irq_pin1   = irq1_q;
  assign irq_shared = irqx_q;
  assign wake_req   = wake_q;
endmodule

// File: rtl/gpio_edge_aggr.sv
module gpio_edge_aggr #(
  parameter int unsigned NUM_BANKS = gpio_eda_pkg::DEF_BANKS,
  parameter int unsigned BANK_W    = gpio_eda_pkg::DEF_BANK_W,
  parameter logic [NUM_BANKS*BANK_W-1:0] WAKE_MASK = gpio_eda_pkg::DEF_WAKE_MASK
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_lvl,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_dir,
  input  logic [NUM_BANKS*BANK_W-1:0] rise_en,
  input  logic [NUM_BANKS*BANK_W-1:0] fall_en,
  input  logic [NUM_BANKS-1:0]        clr_stb,
  input  logic [BANK_W-1:0]           clr_data,
  input  logic                        cpu_halted,
  output logic [NUM_BANKS*BANK_W-1:0] edge_sts,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_shared,
  output logic                        wake_req
);
  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W;

  logic                 primed_q;
  logic [NUM_BANKS-1:0] wake_hit;

  // the previous-level copy holds reset values on the first edge: suppress it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_edge_bank #(
      .BANK_W   (BANK_W),
      .WAKE_MASK(WAKE_MASK[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .primed  (primed_q),
      .lvl     (pin_lvl[b*BANK_W +: BANK_W]),
      .dir     (pin_dir[b*BANK_W +: BANK_W]),
      .rise_en (rise_en[b*BANK_W +: BANK_W]),
      .fall_en (fall_en[b*BANK_W +: BANK_W]),
      .clr_stb (clr_stb[b]),
      .clr_data(clr_data),
      .status  (edge_sts[b*BANK_W +: BANK_W]),
      .wake_hit(wake_hit[b])
    );
  end

  gpio_irq_merge #(
    .NUM_BANKS(NUM_BANKS),
    .NUM_PINS (NUM_PINS)
  ) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (edge_sts),
    .wake_hit  (wake_hit),
    .cpu_halted(cpu_halted),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_shared(irq_shared),
    .wake_req  (wake_req)
  );
endmodule

// File: rtl/gpio_edge_aggr_chk.sv
module gpio_edge_aggr_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_BANKS*BANK_W-1:0] pin_lvl,
  input logic [NUM_BANKS*BANK_W-1:0] pin_dir,
  input logic [NUM_BANKS*BANK_W-1:0] rise_en,
  input logic [NUM_BANKS*BANK_W-1:0] fall_en,
  input logic [NUM_BANKS-1:0]        clr_stb,
  input logic [BANK_W-1:0]           clr_data,
  input logic                        cpu_halted,
  input logic [NUM_BANKS*BANK_W-1:0] edge_sts,
  input logic                        irq_pin0,
  input logic                        irq_pin1,
  input logic                        irq_shared,
  input logic                        wake_req
);
  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W;

  // R1
  rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_sts & ~$past(edge_sts)) & $past(pin_lvl) & ~$past(rise_en)) == '0);

  // R2
  fall_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_sts & ~$past(edge_sts)) & ~$past(pin_lvl) & ~$past(fall_en)) == '0);

  // R3
  output_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_sts & ~$past(edge_sts)) & $past(pin_dir)) == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_stb[b] |=> ($past(edge_sts[b*BANK_W +: BANK_W]) & ~edge_sts[b*BANK_W +: BANK_W]) == '0);
    // R4
    clear_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb[b] && $stable(pin_lvl[b*BANK_W +: BANK_W])
      |=> (edge_sts[b*BANK_W +: BANK_W] & $past(clr_data)) == '0);
  end

  // R6
  irq_pin0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_pin0 == $past(edge_sts[0]));

  // R6
  irq_pin1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_pin1 == $past(edge_sts[1]));

  // R7
  irq_shared_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_shared == $past(|edge_sts[NUM_PINS-1:2]));

  // R8
  wake_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(cpu_halted));
endmodule

bind gpio_edge_aggr gpio_edge_aggr_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_lvl   (pin_lvl),
  .pin_dir   (pin_dir),
  .rise_en   (rise_en),
  .fall_en   (fall_en),
  .clr_stb   (clr_stb),
  .clr_data  (clr_data),
  .cpu_halted(cpu_halted),
  .edge_sts  (edge_sts),
  .irq_pin0  (irq_pin0),
  .irq_pin1  (irq_pin1),
  .irq_shared(irq_shared),
  .wake_req  (wake_req)
);

// File: tb/sim_gpio_edge_aggr.sv
module sim_gpio_edge_aggr;
  localparam int NP = 128;
  localparam int NV = 10;
  // {pin[6:0], new level, input, rise_en, fall_en, expected status}
  localparam logic [11:0] VEC [NV] = '{
    {7'd5,   1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {7'd5,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {7'd40,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd40,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {7'd70,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'd127, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {7'd0,   1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {7'd1,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {7'd64,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_lvl, pin_dir, rise_en, fall_en;
  logic [3:0]    clr_stb;
  logic [31:0]   clr_data;
  logic          cpu_halted;
  logic [NP-1:0] edge_sts;
  logic          irq_pin0, irq_pin1, irq_shared, wake_req;
  int            n_chk = 0;
  int            n_err = 0;

  always #5 clk = ~clk;

  gpio_edge_aggr u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_dir(pin_dir),
    .rise_en(rise_en), .fall_en(fall_en), .clr_stb(clr_stb),
    .clr_data(clr_data), .cpu_halted(cpu_halted), .edge_sts(edge_sts),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared),
    .wake_req(wake_req)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_stb = 4'hF; clr_data = '1; step(); clr_stb = '0; clr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [NP-1:0] exp_v;
    rst_n = 1'b0; pin_lvl = '0; pin_dir = '0; rise_en = '1; fall_en = '1;
    clr_stb = '0; clr_data = '0; cpu_halted = 1'b0;
    pin_lvl[3] = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9: reset state and no detection on first edge with pin 3 held high
    chk("R9 status after reset", edge_sts, '0);
    chk("R9 irq/wake after reset", {irq_pin0, irq_pin1, irq_shared, wake_req}, '0);
    step();
    chk("R9 pin held high through reset", edge_sts, '0);

    // vector table: R1 R2 R3
    for (int v = 0; v < NV; v++) begin
      int p;
      p = int'(VEC[v][11:5]);
      pin_dir = '1; rise_en = '0; fall_en = '0;
      pin_lvl[p] = ~VEC[v][4];
      step(); step();
      clear_all();
      pin_dir[p] = ~VEC[v][3];
      rise_en[p] = VEC[v][2];
      fall_en[p] = VEC[v][1];
      step();
      pin_lvl[p] = VEC[v][4];
      step();
      exp_v = '0; exp_v[p] = VEC[v][0];
      chk($sformatf("R1/R2/R3 vector %0d pin %0d", v, p), edge_sts, exp_v);
    end

    // R6: pin 0 status then irq one cycle later
    pin_dir = '1; rise_en = '0; fall_en = '0; pin_lvl = '0;
    step(); step(); clear_all(); step(); step();
    pin_dir = '0; rise_en = '1;
    step();
    pin_lvl[0] = 1'b1;
    step();
    chk("R6 irq_pin0 not yet", NP'(irq_pin0), '0);
    step();
    chk("R6 irq_pin0 follows status", NP'(irq_pin0), NP'(1));
    chk("R7 irq_shared idle", NP'(irq_shared), '0);
    pin_lvl[1] = 1'b1;
    step(); step();
    chk("R6 irq_pin1 follows status", NP'(irq_pin1), NP'(1));
    clear_all();
    chk("R6 status cleared", edge_sts, '0);
    chk("R6 irq_pin0 still high one cycle", NP'(irq_pin0), NP'(1));
    step();
    chk("R6 irq lines drop", NP'({irq_pin0, irq_pin1}), '0);

    // R7: shared line from pin 97
    pin_lvl[97] = 1'b1;
    step();
    chk("R7 irq_shared not yet", NP'(irq_shared), '0);
    step();
    chk("R7 irq_shared from pin 97", NP'(irq_shared), NP'(1));
    clear_all(); step();

    // R5: edge and clear of pin 33 in the same cycle
    pin_lvl[33] = 1'b1; clr_stb = 4'b0010; clr_data = 32'h2;
    step();
    clr_stb = '0; clr_data = '0;
    exp_v = '0; exp_v[33] = 1'b1;
    chk("R5 edge wins over clear", edge_sts, exp_v);

    // R4: per-bank clear
    pin_lvl[0] = 1'b0; fall_en = '0; fall_en[0] = 1'b1;
    step();
    exp_v[0] = 1'b1;
    chk("R4 two sticky bits", edge_sts, exp_v);
    clr_stb = 4'b0001; clr_data = 32'hFFFF_FFFE;
    step();
    clr_stb = '0;
    chk("R4 clear leaves zero-data bit and other bank", edge_sts, exp_v);
    clr_stb = 4'b0010; clr_data = 32'h2;
    step();
    clr_stb = '0;
    exp_v[33] = 1'b0;
    chk("R4 bank 1 clear only", edge_sts, exp_v);
    step();
    chk("R4 sticky without clear", edge_sts, exp_v);
    clear_all();

    // R8: wake pulses
    rise_en = '0; fall_en = '0; cpu_halted = 1'b1;
    step();
    pin_lvl[0] = 1'b1;
    step();
    chk("R8 wake from pin 0", NP'(wake_req), NP'(1));
    step();
    chk("R8 wake is one cycle", NP'(wake_req), '0);
    pin_lvl[2] = 1'b1;
    step();
    chk("R8 pin 2 not wake-capable", NP'(wake_req), '0);
    pin_lvl[96] = 1'b1;
    step();
    chk("R8 wake from pin 96", NP'(wake_req), NP'(1));
    pin_dir[96] = 1'b1;
    step();
    pin_lvl[96] = 1'b0;
    step();
    chk("R8 output pin no wake", NP'(wake_req), '0);
    cpu_halted = 1'b0;
    pin_lvl[0] = 1'b0;
    step();
    chk("R8 no wake when running", NP'(wake_req), '0);
    chk("R8 enables off, no status", edge_sts, '0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule